// File: doc/BRIEF.md
# Hybrid Ripple-Lookahead 64-bit Adder

A combinational binary adder that takes two 64-bit operands and a carry-in. It returns a 64-bit sum and a carry-out that together equal the 65-bit value of the operands plus the carry-in. The operands are cut into sixteen slices of four bits each. Inside a slice, the carries pass from bit to bit through majority-function full-adder cells.

Lookahead logic supplies only the carry into each slice. It works on two levels:
- The first level folds four slice propagate/generate pairs into one 16-bit section pair. It also produces the carries into the slices at the upper three offsets of a section, counted from that section's carry-in.
- The second level folds the four section pairs. It produces the carries into bits 16, 32 and 48 and the final carry-out.

Because no per-bit carry is predicted, each per-bit propagate and generate net feeds only its own slice's lookahead term. This keeps the fan-out of those nets small. The longest path starts at the lookahead tree, enters the top slice, ripples through its three internal carries and ends at sum bit 63.

The block has no clock and no state. A caller that needs timing closure places registers around it.

Top module: `rippleLookaheadAdder`

## Requirements
- R1: For every input, {carryOut, sumOut} equals the 65-bit result of opA + opB + carryIn.
- R2: A carry produced inside a 4-bit slice reaches the next bit of the same slice. For example, 0x7 + 0x1 gives 0x8.
- R3: A carry leaving a 4-bit slice reaches the next slice inside the same 16-bit section. For example, 0xF + 0x1 gives 0x10.
- R4: A carry leaving a 16-bit section reaches the next section. For example, 0xFFFF + 0x1 gives 0x10000, and 0x0000_FFFF_FFFF_FFFF with carryIn = 1 gives 0x0001_0000_0000_0000.
- R5: When opA equals the bitwise inverse of opB, every bit propagates:
  - with carryIn = 1, sumOut is zero and carryOut is 1;
  - with carryIn = 0, sumOut is all ones and carryOut is 0.
- R6: All ones plus one, whether the one comes from opB or from carryIn, gives sumOut = 0 and carryOut = 1.
- R7: carryOut is 1 exactly when the true sum is 2^64 or more. For example, 0x8000_0000_0000_0000 + 0x8000_0000_0000_0000 gives sumOut = 0 and carryOut = 1.
- R8: With both operands zero, sumOut equals carryIn in bit 0 and zero in all other bits, and carryOut is 0.
- R9: The outputs follow a change of the inputs within the same clock period of the surrounding logic. The block adds no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 64 | Low 64 bits of the sum |
| carryOut | output | 1 | Carry out of bit 63 |

## Verification
Two carry mechanisms can act on the same sum bit in one evaluation: a carry rippling inside a slice and a lookahead-predicted carry entering that slice. The alternating patterns with carryIn set, and the inverted-operand patterns, drive the full propagate chain. In those vectors every slice-entry carry depends on the tree, while every internal bit depends on the ripple. Each result is judged against a 65-bit behavioural addition computed in the bench, both for the table vectors and for random operands.

// File: rtl/rlaPkg.sv
package rlaPkg;
  typedef struct packed {
    logic prop;
    logic gen;
  } pgPair_t;

  function automatic logic majority3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  function automatic logic carryFrom(input pgPair_t pg, input logic cin);
    return pg.gen | (pg.prop & cin);
  endfunction
endpackage

// File: rtl/rlaRippleGroup.sv
module rlaRippleGroup
  import rlaPkg::*;
#(
  parameter int GROUP_W = 4
) (
  input  logic [GROUP_W-1:0] aBits,
  input  logic [GROUP_W-1:0] bBits,
  input  logic               groupCarryIn,
  output logic [GROUP_W-1:0] sumBits,
  output pgPair_t            groupPg
);
  logic [GROUP_W-1:0] bitProp;
  logic [GROUP_W-1:0] bitGen;
  logic [GROUP_W-1:0] rippleCarry;

  assign bitProp = aBits ^ bBits;
  assign bitGen  = aBits & bBits;
  assign rippleCarry[0] = groupCarryIn;

  // internal carries ripple; the slice carry-out is taken from lookahead
  for (genvar i = 0; i < GROUP_W - 1; i++) begin : g_cell
    assign rippleCarry[i+1] = majority3(aBits[i], bBits[i], rippleCarry[i]);
  end

  assign sumBits = bitProp ^ rippleCarry;

  always_comb begin
    logic accGen;
    logic accProp;
    accGen  = 1'b0;
    accProp = 1'b1;
    for (int i = 0; i < GROUP_W; i++) begin
      accGen  = bitGen[i] | (bitProp[i] & accGen);
      accProp = accProp & bitProp[i];
    end
    groupPg.gen  = accGen;
    groupPg.prop = accProp;
  end
endmodule

// File: rtl/rlaLookaheadUnit.sv
module rlaLookaheadUnit
  import rlaPkg::*;
#(
  parameter int FAN = 4
) (
  input  pgPair_t [FAN-1:0] childPg,
  input  logic              unitCarryIn,
  output logic    [FAN-1:0] childCarry,
  output pgPair_t           unitPg
);
  // sum-of-products form: each carry is a flat OR of AND terms
  always_comb begin
    childCarry[0] = unitCarryIn;
    for (int k = 1; k < FAN; k++) begin
      logic orTerm;
      logic chainAll;
      chainAll = unitCarryIn;
      for (int m = 0; m < k; m++) chainAll = chainAll & childPg[m].prop;
      orTerm = chainAll;
      for (int j = 0; j < k; j++) begin
        logic term;
        term = childPg[j].gen;
        for (int m = j + 1; m < k; m++) term = term & childPg[m].prop;
        orTerm = orTerm | term;
      end
      childCarry[k] = orTerm;
    end
  end

  always_comb begin
    logic genAcc;
    logic propAcc;
    genAcc  = 1'b0;
    propAcc = 1'b1;
    for (int j = 0; j < FAN; j++) begin
      logic term;
      term = childPg[j].gen;
      for (int m = j + 1; m < FAN; m++) term = term & childPg[m].prop;
      genAcc  = genAcc | term;
      propAcc = propAcc & childPg[j].prop;
    end
    unitPg.gen  = genAcc;
    unitPg.prop = propAcc;
  end
endmodule

// File: rtl/rlaSection.sv
module rlaSection
  import rlaPkg::*;
#(
  parameter int GROUP_W = 4,
  parameter int FAN     = 4,
  localparam int SEC_W  = GROUP_W * FAN
) (
  input  logic [SEC_W-1:0] aSec,
  input  logic [SEC_W-1:0] bSec,
  input  logic             secCarryIn,
  output logic [SEC_W-1:0] sumSec,
  output pgPair_t          secPg
);
  pgPair_t [FAN-1:0] groupPg;
  logic    [FAN-1:0] groupCarry;

  for (genvar g = 0; g < FAN; g++) begin : g_group
    rlaRippleGroup #(.GROUP_W(GROUP_W)) group_i (
      .aBits       (aSec[g*GROUP_W +: GROUP_W]),
      .bBits       (bSec[g*GROUP_W +: GROUP_W]),
      .groupCarryIn(groupCarry[g]),
      .sumBits     (sumSec[g*GROUP_W +: GROUP_W]),
      .groupPg     (groupPg[g])
    );
  end

  rlaLookaheadUnit #(.FAN(FAN)) lookahead_i (
    .childPg    (groupPg),
    .unitCarryIn(secCarryIn),
    .childCarry (groupCarry),
    .unitPg     (secPg)
  );
endmodule

// File: rtl/rippleLookaheadAdder.sv
module rippleLookaheadAdder
  import rlaPkg::*;
#(
  parameter int GROUP_W = 4,
  parameter int FAN     = 4,
  localparam int SEC_W  = GROUP_W * FAN,
  localparam int WIDTH  = SEC_W * FAN
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  pgPair_t [FAN-1:0] sectionPg;
  logic    [FAN-1:0] sectionCarry;
  pgPair_t           wholePg;

  for (genvar s = 0; s < FAN; s++) begin : g_section
    rlaSection #(.GROUP_W(GROUP_W), .FAN(FAN)) section_i (
      .aSec      (opA[s*SEC_W +: SEC_W]),
      .bSec      (opB[s*SEC_W +: SEC_W]),
      .secCarryIn(sectionCarry[s]),
      .sumSec    (sumOut[s*SEC_W +: SEC_W]),
      .secPg     (sectionPg[s])
    );
  end

  rlaLookaheadUnit #(.FAN(FAN)) topLookahead_i (
    .childPg    (sectionPg),
    .unitCarryIn(carryIn),
    .childCarry (sectionCarry),
    .unitPg     (wholePg)
  );

  assign carryOut = carryFrom(wholePg, carryIn);
endmodule

// File: rtl/rippleLookaheadAdder_chk.sv
module rippleLookaheadAdder_chk #(
  parameter int WIDTH = 64
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [WIDTH-1:0] sumOut,
  input logic             carryOut
);
  logic [WIDTH:0] refSum;
  assign refSum = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};

  always_comb begin
    if (!$isunknown({opA, opB, carryIn, sumOut, carryOut})) begin
      a_r1_sum_matches: assert ({carryOut, sumOut} == refSum);
      if (opA == ~opB) begin
        a_r5_propagate_chain: assert (carryOut == carryIn && sumOut == {WIDTH{~carryIn}});
      end
      if (opA == {WIDTH{1'b1}} && opB == '0 && carryIn) begin
        a_r6_all_ones_wrap: assert (sumOut == '0 && carryOut);
      end
      if (opA == '0 && opB == '0) begin
        a_r8_zero_operands: assert (!carryOut && sumOut == {{(WIDTH-1){1'b0}}, carryIn});
      end
      if (opA[WIDTH-1] && opB[WIDTH-1]) begin
        a_r7_top_bits_carry: assert (carryOut);
      end
    end
  end
endmodule

bind rippleLookaheadAdder rippleLookaheadAdder_chk #(.WIDTH(WIDTH)) chk_i (
  .opA(opA), .opB(opB), .carryIn(carryIn), .sumOut(sumOut), .carryOut(carryOut)
);

// File: tb/rippleLookaheadAdder_tb_top.sv
module rippleLookaheadAdder_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [63:0] sumOut;
  logic        carryOut;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  rippleLookaheadAdder dut_i (
    .opA(opA), .opB(opB), .carryIn(carryIn), .sumOut(sumOut), .carryOut(carryOut)
  );

  // {a, b, cin, expected carryOut, expected sum}
  localparam int NVEC = 12;
  localparam logic [193:0] VEC [NVEC] = '{
    {64'h0, 64'h0, 1'b0, 1'b0, 64'h0},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 1'b1, 64'h0},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 1'b1, 64'h0},
    {64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
    {64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1, 1'b1, 64'h0},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
    {64'h7, 64'h1, 1'b0, 1'b0, 64'h8},
    {64'hF, 64'h1, 1'b0, 1'b0, 64'h10},
    {64'hFFFF, 64'h1, 1'b0, 1'b0, 64'h1_0000},
    {64'h0000_FFFF_FFFF_FFFF, 64'h0, 1'b1, 1'b0, 64'h0001_0000_0000_0000},
    {64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 1'b1, 64'h0},
    {64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 1'b0, 1'b0, 64'h2222_2222_2222_2211}
  };
  localparam string VEC_REQ [NVEC] = '{
    "R8 zero", "R6 ones+opB", "R6 ones+cin", "R5 alt cin0", "R5 alt cin1", "R7 max",
    "R2 in-slice", "R3 slice edge", "R4 section edge", "R4 wide chain", "R7 top bits",
    "R1 mixed"
  };

  task automatic applyAndCheck(input logic [63:0] a, input logic [63:0] b, input logic c,
                               input logic expCo, input logic [63:0] expSum, input string tag);
    @(posedge clk);
    #0.5;
    opA = a; opB = b; carryIn = c;
    @(negedge clk);
    checkCount++;
    if ({carryOut, sumOut} !== {expCo, expSum}) begin
      failCount++;
      $display("FAIL %s: actual co=%b sum=%h expected co=%b sum=%h", tag, carryOut, sumOut,
               expCo, expSum);
    end
  endtask

  task automatic refCheck(input logic [63:0] a, input logic [63:0] b, input logic c,
                          input string tag);
    logic [64:0] r;
    r = {1'b0, a} + {1'b0, b} + {64'h0, c};
    applyAndCheck(a, b, c, r[64], r[63:0], tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R8: quiescent state with zero inputs
    @(negedge clk);
    checkCount++;
    if ({carryOut, sumOut} !== 65'h0) begin
      failCount++;
      $display("FAIL R8 reset-state: actual co=%b sum=%h expected co=0 sum=0", carryOut, sumOut);
    end
    for (int i = 0; i < NVEC; i++) begin
      applyAndCheck(VEC[i][193:130], VEC[i][129:66], VEC[i][65], VEC[i][64], VEC[i][63:0],
                    VEC_REQ[i]);
    end
    // R5: inverted operands, both carry-in values
    applyAndCheck(64'h0123_4567_89AB_CDEF, ~64'h0123_4567_89AB_CDEF, 1'b1, 1'b1, 64'h0,
                  "R5 inverse cin1");
    applyAndCheck(64'h0123_4567_89AB_CDEF, ~64'h0123_4567_89AB_CDEF, 1'b0, 1'b0,
                  64'hFFFF_FFFF_FFFF_FFFF, "R5 inverse cin0");
    // R8: zero operands with carry-in set
    applyAndCheck(64'h0, 64'h0, 1'b1, 1'b0, 64'h1, "R8 zero cin1");
    // R3/R4: carry across each section boundary
    for (int s = 1; s < 4; s++) begin
      refCheck((64'h1 << (16 * s)) - 64'h1, 64'h0, 1'b1, "R4 boundary");
    end
    for (int g = 1; g < 16; g++) begin
      refCheck((64'h1 << (4 * g)) - 64'h1, 64'h1, 1'b0, "R3 boundary");
    end
    // R9: a new operand pair shows its result in the same period
    applyAndCheck(64'h5, 64'h3, 1'b0, 1'b0, 64'h8, "R9 same-period");
    applyAndCheck(64'hFFFF_FFFF_0000_0000, 64'h1_0000_0000, 1'b0, 1'b1, 64'h0, "R9 same-period");
    // R1/R2: random operands
    for (int n = 0; n < 400; n++) begin
      refCheck({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1 random");
    end
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end
endmodule